// File: doc/BRIEF.md
# PCI Parity and System Error Reporter

This block sits beside the address/data path of a PCI agent and handles bus parity and system-error reporting. When the agent drives an address or data phase, the block computes even parity over the 32 AD bits and the 4 command/byte-enable bits. It presents that parity bit, with its output enable, one clock later. When the agent receives a phase, the block keeps the computed parity and compares it with the PAR value sampled one clock later.

A small classifier combines the parity outcomes with the target-abort and master-abort strobes and the current bus command. It decides whether the event is a system error. If so, it raises SERR for exactly one clock, provided the SERR enable bit of the command register is set. Each SERR assertion sets a sticky signaled-system-error status bit, which software clears by writing a one to it. For an address parity error that raises SERR, a companion flag tells the target logic that it must not end the transaction with retry or disconnect.

All bus inputs are per-clock strobes and levels taken from the bus state machine. The block never stalls, so none of its pins carry back-pressure. Register writes are single-cycle strobes without a handshake. Outputs are active high; conversion to bus polarity is done outside.

Top module: `pci_err_reporter`

## Requirements
- R1: In the cycle after a driven phase (`drive_i` high with `addr_ph_i` or `data_ph_i`), `par_oe_o` is high and `par_o` makes the count of ones over that phase's `ad_i`, `cbe_i` and `par_o` even. After a received phase or an idle cycle, `par_oe_o` is low.
- R2: After a received address phase, `par_i` is checked in the next cycle. A value that breaks even parity is an address parity error and raises SERR. Correct parity raises nothing.
- R3: A data parity error raises SERR only when the command of that data phase is the special cycle (`cmd_i` = 4'b0001). A data parity error under any other command, for example memory write 4'b0111, does not raise SERR.
- R4: A `tgt_abort_i` strobe raises SERR.
- R5: A `mst_abort_i` strobe raises SERR unless `cmd_i` in that cycle is configuration read (4'b1010), configuration write (4'b1011) or special cycle (4'b0001).
- R6: `serr_o` goes high in the cycle after the cause is sampled and stays high for exactly one clock. Several causes in the same cycle give one single pulse.
- R7: SERR is raised only while the command-register enable is set. A write with `cmd_we_i` loads it from bit 8 of `cmd_wdata_i`, and `serr_en_o` shows its value.
- R8: `sig_serr_o` (status bit 14) sets together with every SERR pulse and stays set. A write with `sts_we_i` clears it only when bit 14 of `sts_wdata_i` is one. A new SERR in the same cycle wins over the clear.
- R9: `no_retry_o` pulses together with `serr_o` only when an address parity error is among the causes.
- R10: During and right after reset, `par_oe_o`, `serr_o`, `no_retry_o`, `serr_en_o` and `sig_serr_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_i | input | 32 | Address/data bits of the current phase |
| cbe_i | input | 4 | Command/byte-enable bits of the current phase |
| par_i | input | 1 | Sampled PAR from the bus |
| addr_ph_i | input | 1 | Current cycle is an address phase |
| data_ph_i | input | 1 | Current cycle is a data phase |
| drive_i | input | 1 | This agent drives AD in the current phase |
| cmd_i | input | 4 | Command of the current transaction |
| tgt_abort_i | input | 1 | Target-abort event strobe |
| mst_abort_i | input | 1 | Master-abort event strobe |
| cmd_we_i | input | 1 | Command register write strobe |
| cmd_wdata_i | input | 16 | Command register write data |
| sts_we_i | input | 1 | Status register write strobe (write-one-to-clear) |
| sts_wdata_i | input | 16 | Status register write data |
| par_o | output | 1 | Generated parity for the previous driven phase |
| par_oe_o | output | 1 | Enable for driving `par_o` onto the bus |
| serr_o | output | 1 | One-clock system-error pulse |
| no_retry_o | output | 1 | Target must not retry or disconnect |
| serr_en_o | output | 1 | Command register SERR enable (bit 8) |
| sig_serr_o | output | 1 | Sticky signaled-system-error status (bit 14) |

## Verification
The hardest cases to reach from the ports depend on timing across two cycles. An address parity error exists only when a received address phase is followed, exactly one clock later, by a corrupted PAR. The multi-cause case needs an abort strobe to land in that same later cycle. The driver task drives the phase, then on the next falling edge inverts the correct parity on `par_i` and, when asked, raises an abort strobe in the same cycle. It queues the expected pulse for the following cycle and a quiet cycle after that, so a second pulse shows up as a failure.

// File: rtl/pci_err_pkg.sv
package pci_err_pkg;

  localparam int unsigned CMD_W = 4;

  typedef enum logic [CMD_W-1:0] {
    CMD_INTACK  = 4'h0,
    CMD_SPECIAL = 4'h1,
    CMD_IO_RD   = 4'h2,
    CMD_IO_WR   = 4'h3,
    CMD_MEM_RD  = 4'h6,
    CMD_MEM_WR  = 4'h7,
    CMD_CFG_RD  = 4'hA,
    CMD_CFG_WR  = 4'hB
  } pci_cmd_e;

  typedef struct packed {
    logic addr_perr;
    logic spec_perr;
    logic tgt_abort;
    logic mst_abort;
  } serr_cause_t;

  function automatic logic ma_exempt(input logic [CMD_W-1:0] cmd);
    return (cmd == CMD_CFG_RD) || (cmd == CMD_CFG_WR) || (cmd == CMD_SPECIAL);
  endfunction

endpackage

// File: rtl/pci_par_pipe.sv
module pci_par_pipe
  import pci_err_pkg::*;
#(
  parameter int unsigned AD_W  = 32,
  parameter int unsigned CBE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AD_W-1:0]  ad_i,
  input  logic [CBE_W-1:0] cbe_i,
  input  logic             par_i,
  input  logic             addr_ph_i,
  input  logic             data_ph_i,
  input  logic             drive_i,
  input  logic [CMD_W-1:0] cmd_i,
  output logic             par_o,
  output logic             par_oe_o,
  output logic             addr_perr_o,
  output logic             spec_perr_o
);

  localparam int unsigned LANE_W = AD_W / CBE_W;

  logic [CBE_W-1:0] lane_par;
  logic             par_next;
  logic             phase;

  // One partial parity per byte lane: data bits plus its byte enable.
  for (genvar g = 0; g < CBE_W; g++) begin : g_lane
    assign lane_par[g] = (^ad_i[g*LANE_W +: LANE_W]) ^ cbe_i[g];
  end

  assign par_next = ^lane_par;
  assign phase    = addr_ph_i | data_ph_i;

  logic             ph_v_q;
  logic             ph_addr_q;
  logic             drv_q;
  logic             par_q;
  logic [CMD_W-1:0] cmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_v_q    <= 1'b0;
      ph_addr_q <= 1'b0;
      drv_q     <= 1'b0;
      par_q     <= 1'b0;
      cmd_q     <= '0;
    end else begin
      ph_v_q <= phase;
      if (phase) begin
        ph_addr_q <= addr_ph_i;
        drv_q     <= drive_i;
        par_q     <= par_next;
        cmd_q     <= cmd_i;
      end
    end
  end

  logic rx_err;

  assign par_o       = par_q;
  assign par_oe_o    = ph_v_q & drv_q;
  assign rx_err      = ph_v_q & ~drv_q & (par_i != par_q);
  assign addr_perr_o = rx_err & ph_addr_q;
  assign spec_perr_o = rx_err & ~ph_addr_q & (cmd_q == CMD_SPECIAL);

  AST_PAR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    par_oe_o |-> ($countones({$past(ad_i), $past(cbe_i), par_o}) % 2 == 0)); // R1

  AST_OE_AFTER_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase && drive_i) |=> par_oe_o); // R1

  AST_NO_OE_AFTER_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (!phase || !drive_i) |=> !par_oe_o); // R1

endmodule

// File: rtl/pci_serr_classify.sv
module pci_serr_classify
  import pci_err_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_perr_i,
  input  logic             spec_perr_i,
  input  logic             tgt_abort_i,
  input  logic             mst_abort_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             serr_en_i,
  output logic             fire_o,
  output logic             serr_o,
  output logic             no_retry_o
);

  serr_cause_t cause;

  always_comb begin
    cause.addr_perr = addr_perr_i;
    cause.spec_perr = spec_perr_i;
    cause.tgt_abort = tgt_abort_i;
    cause.mst_abort = mst_abort_i & ~ma_exempt(cmd_i);
  end

  // Any number of causes collapse into one request.
  assign fire_o = serr_en_i & (|cause);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      serr_o     <= 1'b0;
      no_retry_o <= 1'b0;
    end else begin
      serr_o     <= fire_o;
      no_retry_o <= fire_o & cause.addr_perr;
    end
  end

  AST_MA_EXEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_abort_i && ma_exempt(cmd_i) && !addr_perr_i && !spec_perr_i && !tgt_abort_i)
      |=> !serr_o); // R5

  AST_TA_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_abort_i && serr_en_i) |=> serr_o); // R4

  AST_GATED_BY_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !serr_en_i |=> !serr_o); // R7

  AST_NR_WITH_SERR: assert property (@(posedge clk) disable iff (!rst_n)
    no_retry_o |-> serr_o); // R9

  AST_APE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_perr_i && serr_en_i) |=> (serr_o && no_retry_o)); // R2

endmodule

// File: rtl/pci_err_csr.sv
module pci_err_csr #(
  parameter int unsigned REG_W   = 16,
  parameter int unsigned EN_BIT  = 8,
  parameter int unsigned STS_BIT = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we_i,
  input  logic [REG_W-1:0] cmd_wdata_i,
  input  logic             sts_we_i,
  input  logic [REG_W-1:0] sts_wdata_i,
  input  logic             set_sts_i,
  output logic             serr_en_o,
  output logic             sig_serr_o
);

  logic sts_clr;
  logic unused_bits;

  assign sts_clr     = sts_we_i & sts_wdata_i[STS_BIT];
  assign unused_bits = ^{cmd_wdata_i, sts_wdata_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      serr_en_o <= 1'b0;
    end else if (cmd_we_i) begin
      serr_en_o <= cmd_wdata_i[EN_BIT];
    end
  end

  // A new error wins over a clear arriving in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_serr_o <= 1'b0;
    end else if (set_sts_i) begin
      sig_serr_o <= 1'b1;
    end else if (sts_clr) begin
      sig_serr_o <= 1'b0;
    end
  end

  AST_STS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_sts_i |=> sig_serr_o); // R8

  AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_serr_o && !sts_clr) |=> sig_serr_o); // R8

  AST_STS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_clr && !set_sts_i) |=> !sig_serr_o); // R8

endmodule

// File: rtl/pci_err_reporter.sv
module pci_err_reporter
  import pci_err_pkg::*;
#(
  parameter int unsigned AD_W    = 32,
  parameter int unsigned CBE_W   = 4,
  parameter int unsigned REG_W   = 16,
  parameter int unsigned EN_BIT  = 8,
  parameter int unsigned STS_BIT = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AD_W-1:0]  ad_i,
  input  logic [CBE_W-1:0] cbe_i,
  input  logic             par_i,
  input  logic             addr_ph_i,
  input  logic             data_ph_i,
  input  logic             drive_i,
  input  logic [3:0]       cmd_i,
  input  logic             tgt_abort_i,
  input  logic             mst_abort_i,
  input  logic             cmd_we_i,
  input  logic [REG_W-1:0] cmd_wdata_i,
  input  logic             sts_we_i,
  input  logic [REG_W-1:0] sts_wdata_i,
  output logic             par_o,
  output logic             par_oe_o,
  output logic             serr_o,
  output logic             no_retry_o,
  output logic             serr_en_o,
  output logic             sig_serr_o
);

  logic addr_perr;
  logic spec_perr;
  logic fire;

  pci_par_pipe #(
    .AD_W  (AD_W),
    .CBE_W (CBE_W)
  ) u_par (
    .clk         (clk),
    .rst_n       (rst_n),
    .ad_i        (ad_i),
    .cbe_i       (cbe_i),
    .par_i       (par_i),
    .addr_ph_i   (addr_ph_i),
    .data_ph_i   (data_ph_i),
    .drive_i     (drive_i),
    .cmd_i       (cmd_i),
    .par_o       (par_o),
    .par_oe_o    (par_oe_o),
    .addr_perr_o (addr_perr),
    .spec_perr_o (spec_perr)
  );

  pci_serr_classify u_cls (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_perr_i (addr_perr),
    .spec_perr_i (spec_perr),
    .tgt_abort_i (tgt_abort_i),
    .mst_abort_i (mst_abort_i),
    .cmd_i       (cmd_i),
    .serr_en_i   (serr_en_o),
    .fire_o      (fire),
    .serr_o      (serr_o),
    .no_retry_o  (no_retry_o)
  );

  pci_err_csr #(
    .REG_W   (REG_W),
    .EN_BIT  (EN_BIT),
    .STS_BIT (STS_BIT)
  ) u_csr (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_we_i    (cmd_we_i),
    .cmd_wdata_i (cmd_wdata_i),
    .sts_we_i    (sts_we_i),
    .sts_wdata_i (sts_wdata_i),
    .set_sts_i   (fire),
    .serr_en_o   (serr_en_o),
    .sig_serr_o  (sig_serr_o)
  );

  AST_SERR_MARKS_STS: assert property (@(posedge clk) disable iff (!rst_n)
    serr_o |-> sig_serr_o); // R8

  AST_SERR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    serr_o |-> $past(serr_en_o)); // R7

endmodule

// File: tb/pci_err_reporter_tb_top.sv
module pci_err_reporter_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ad_i = '0;
  logic [3:0]  cbe_i = '0;
  logic        par_i = 1'b0;
  logic        addr_ph_i = 1'b0, data_ph_i = 1'b0, drive_i = 1'b0;
  logic [3:0]  cmd_i = '0;
  logic        tgt_abort_i = 1'b0, mst_abort_i = 1'b0;
  logic        cmd_we_i = 1'b0, sts_we_i = 1'b0;
  logic [15:0] cmd_wdata_i = '0, sts_wdata_i = '0;
  logic        par_o, par_oe_o, serr_o, no_retry_o, serr_en_o, sig_serr_o;

  always #10 clk = ~clk; // 50 MHz

  pci_err_reporter dut_i (
    .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .cbe_i(cbe_i), .par_i(par_i),
    .addr_ph_i(addr_ph_i), .data_ph_i(data_ph_i), .drive_i(drive_i), .cmd_i(cmd_i),
    .tgt_abort_i(tgt_abort_i), .mst_abort_i(mst_abort_i),
    .cmd_we_i(cmd_we_i), .cmd_wdata_i(cmd_wdata_i),
    .sts_we_i(sts_we_i), .sts_wdata_i(sts_wdata_i),
    .par_o(par_o), .par_oe_o(par_oe_o), .serr_o(serr_o), .no_retry_o(no_retry_o),
    .serr_en_o(serr_en_o), .sig_serr_o(sig_serr_o)
  );

  int pe = 0;
  always @(posedge clk) pe <= pe + 1;

  int n_chk = 0;
  int n_fail = 0;
  bit en_m = 1'b0;
  bit sig_m = 1'b0;

  typedef struct {
    int    at;
    bit    is_par;
    bit    e_oe;
    bit    e_par;
    bit    chk_par;
    bit    e_serr;
    bit    e_nr;
    bit    e_sig;
    string req;
  } exp_t;

  exp_t q[$];

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops expectations whose cycle has come and compares them.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      while (q.size() > 0 && q[0].at <= pe) begin
        exp_t e;
        e = q.pop_front();
        if (e.at < pe) chk(e.req, "stale expectation", 32'(pe), 32'(e.at));
        else if (e.is_par) begin
          chk(e.req, "par_oe_o", 32'(par_oe_o), 32'(e.e_oe));
          if (e.chk_par) chk(e.req, "par_o", 32'(par_o), 32'(e.e_par));
        end else begin
          chk(e.req, "serr_o", 32'(serr_o), 32'(e.e_serr));
          chk(e.req, "no_retry_o", 32'(no_retry_o), 32'(e.e_nr));
          chk(e.req, "sig_serr_o", 32'(sig_serr_o), 32'(e.e_sig));
        end
      end
    end
  end

  function automatic bit exempt(logic [3:0] c);
    return (c == 4'hA) || (c == 4'hB) || (c == 4'h1);
  endfunction

  task automatic push_serr(int at, bit s, bit nr, string req);
    exp_t e;
    e.at = at; e.is_par = 1'b0; e.e_oe = 1'b0; e.e_par = 1'b0; e.chk_par = 1'b0;
    e.e_serr = s; e.e_nr = nr; e.e_sig = sig_m; e.req = req;
    q.push_back(e);
  endtask

  // Driver: one phase, then PAR (and optional aborts) a clock later.
  task automatic phase_op(bit is_addr, bit drv, logic [31:0] ad, logic [3:0] cbe,
                          logic [3:0] cmd, bit bad, bit ta, bit ma, string req);
    int p;
    exp_t e;
    bit perr, fire;
    @(negedge clk);
    p = pe;
    addr_ph_i = is_addr; data_ph_i = !is_addr; drive_i = drv;
    ad_i = ad; cbe_i = cbe; cmd_i = cmd;
    e.at = p + 1; e.is_par = 1'b1; e.e_oe = drv; e.e_par = ^{ad, cbe}; e.chk_par = drv;
    e.e_serr = 1'b0; e.e_nr = 1'b0; e.e_sig = 1'b0; e.req = req;
    q.push_back(e);
    @(negedge clk);
    addr_ph_i = 1'b0; data_ph_i = 1'b0; drive_i = 1'b0; ad_i = '0; cbe_i = '0;
    par_i = drv ? 1'b0 : ((^{ad, cbe}) ^ bad);
    tgt_abort_i = ta; mst_abort_i = ma;
    perr = !drv && bad;
    fire = en_m && ((perr && is_addr) || (perr && !is_addr && cmd == 4'h1) ||
                    ta || (ma && !exempt(cmd)));
    if (fire) sig_m = 1'b1;
    push_serr(p + 2, fire, fire && perr && is_addr, req);
    push_serr(p + 3, 1'b0, 1'b0, req);
    @(negedge clk);
    par_i = 1'b0; tgt_abort_i = 1'b0; mst_abort_i = 1'b0; cmd_i = '0;
    @(negedge clk);
  endtask

  task automatic abort_op(bit ta, bit ma, logic [3:0] cmd, string req);
    int p;
    bit fire;
    @(negedge clk);
    p = pe;
    tgt_abort_i = ta; mst_abort_i = ma; cmd_i = cmd;
    fire = en_m && (ta || (ma && !exempt(cmd)));
    if (fire) sig_m = 1'b1;
    push_serr(p + 1, fire, 1'b0, req);
    push_serr(p + 2, 1'b0, 1'b0, req);
    @(negedge clk);
    tgt_abort_i = 1'b0; mst_abort_i = 1'b0; cmd_i = '0;
    @(negedge clk);
  endtask

  task automatic write_cmd(logic [15:0] d);
    @(negedge clk);
    cmd_we_i = 1'b1; cmd_wdata_i = d; en_m = d[8];
    @(negedge clk);
    cmd_we_i = 1'b0; cmd_wdata_i = '0;
    chk("R7", "serr_en_o", 32'(serr_en_o), 32'(en_m));
  endtask

  task automatic write_sts(logic [15:0] d);
    @(negedge clk);
    sts_we_i = 1'b1; sts_wdata_i = d;
    if (d[14]) sig_m = 1'b0;
    @(negedge clk);
    sts_we_i = 1'b0; sts_wdata_i = '0;
    chk("R8", "sig_serr_o after status write", 32'(sig_serr_o), 32'(sig_m));
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(20 * 20000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: outputs low during reset
    chk("R10", "par_oe_o", 32'(par_oe_o), 0);
    chk("R10", "serr_o", 32'(serr_o), 0);
    chk("R10", "no_retry_o", 32'(no_retry_o), 0);
    chk("R10", "serr_en_o", 32'(serr_en_o), 0);
    chk("R10", "sig_serr_o", 32'(sig_serr_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "serr_o after release", 32'(serr_o), 0);

    // R7: disabled, an address parity error gives no pulse
    phase_op(1'b1, 1'b0, 32'h1234_5678, 4'h6, 4'h6, 1'b1, 1'b0, 1'b0, "R7");
    write_cmd(16'h0100);

    // R1: generated parity under several patterns
    phase_op(1'b1, 1'b1, 32'h0000_0000, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, "R1");
    phase_op(1'b1, 1'b1, 32'hFFFF_FFFF, 4'hE, 4'h7, 1'b0, 1'b0, 1'b0, "R1");
    phase_op(1'b0, 1'b1, 32'hA5A5_0F01, 4'h3, 4'h7, 1'b0, 1'b0, 1'b0, "R1");
    phase_op(1'b0, 1'b1, 32'h8000_0001, 4'h1, 4'h7, 1'b0, 1'b0, 1'b0, "R1");

    // R2: received address phase, good then bad parity
    phase_op(1'b1, 1'b0, 32'hDEAD_BEEF, 4'h6, 4'h6, 1'b0, 1'b0, 1'b0, "R2");
    phase_op(1'b1, 1'b0, 32'hDEAD_BEEF, 4'h6, 4'h6, 1'b1, 1'b0, 1'b0, "R2 R9");

    // R8: clear with other bit leaves status, bit 14 clears
    write_sts(16'h2000);
    write_sts(16'h4000);

    // R3: data parity error, special cycle vs memory write
    phase_op(1'b0, 1'b0, 32'h0000_00FF, 4'h0, 4'h1, 1'b1, 1'b0, 1'b0, "R3");
    write_sts(16'h4000);
    phase_op(1'b0, 1'b0, 32'h0000_00FF, 4'h0, 4'h7, 1'b1, 1'b0, 1'b0, "R3");

    // R4: target abort
    abort_op(1'b1, 1'b0, 4'h7, "R4");
    write_sts(16'h4000);

    // R5: master abort by command
    abort_op(1'b0, 1'b1, 4'hA, "R5");
    abort_op(1'b0, 1'b1, 4'hB, "R5");
    abort_op(1'b0, 1'b1, 4'h1, "R5");
    abort_op(1'b0, 1'b1, 4'h6, "R5");
    write_sts(16'h4000);

    // R6: address parity error plus both aborts in one cycle, one pulse
    phase_op(1'b1, 1'b0, 32'h0F0F_0F0F, 4'h2, 4'h6, 1'b1, 1'b1, 1'b1, "R6");
    // R9: data parity error on special cycle gives SERR without inhibit
    phase_op(1'b0, 1'b0, 32'h1111_0000, 4'hF, 4'h1, 1'b1, 1'b0, 1'b0, "R9");

    // R7: disable again, target abort ignored
    write_cmd(16'hFEFF);
    abort_op(1'b1, 1'b0, 4'h7, "R7");

    repeat (4) @(negedge clk);
    chk("R6", "expectations left", 32'(q.size()), 0);
    finish_run();
  end

endmodule